// File: doc/BRIEF.md
# Fast Page Mode DRAM Sequencer

This block sits between a simple single-word request channel and one 4M x 4 fast page mode DRAM device. A client offers a read or a write with a 22-bit word address and a 4-bit data word over a valid/ready handshake. The block splits the address into a row half and a column half and time-multiplexes them onto an 11-bit address bus. It generates the active-low row strobe, column strobe, write enable and output enable. Read data comes back as a one-cycle response pulse.

After an access the row stays open, with the row strobe held low, so that a later request to the same row needs only a column strobe pulse. A request to another row closes the page, waits out the precharge and opens the new row. Every analog limit of the memory is a parameter given in clock cycles. Where two limits constrain the same interval, the block derives the binding count from them. The row is closed before the longest allowed row-strobe low time runs out. A separate refresh scheduler raises a request line. The block closes any open row, lets the precharge complete and then grants the bus by holding its own strobes inactive until the request is withdrawn.

Writes are always early writes: write enable is low before the column strobe falls and output enable stays high. The memory's output buffer therefore never turns on during a write.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row half is `req_addr[21:11]`, present on `dram_a` when `dram_ras_n` falls. The column half is `req_addr[10:0]`, present on `dram_a` when `dram_cas_n` falls.
- R2: Every accepted read produces exactly one cycle of `rsp_valid`, carrying the value on `dram_dq_in` at the clock edge where the column strobe rises. An accepted write produces no response.
- R3: The first column strobe of a row falls no sooner than max(T_RCD, T_RAC - T_CAS) cycles after the row strobe falls. The column strobe falls only while the row strobe is low, and it stays low for exactly T_CAS cycles.
- R4: While a row is open, a request to that row is served with a column strobe pulse alone, with no new row strobe fall. Between column pulses the column strobe stays high for at least max(T_CP, T_PC - T_CAS) cycles.
- R5: A request to a row other than the open one closes the row and then opens the requested row, costing exactly one new row strobe fall.
- R6: The row strobe stays high for at least max(T_RP, T_RC - T_RAS_MIN) cycles before each fall. Each low period lasts at least T_RAS_MIN cycles.
- R7: The row strobe rises no sooner than T_RHCP cycles after the last column strobe rise.
- R8: The row strobe never stays low for more than T_RAS_MAX cycles. An open row is closed ahead of that limit even when same-row requests keep arriving, or when no request arrives.
- R9: For a write, `dram_we_n` is low and `dram_oe_n` is high when the column strobe falls, and `dram_dq_oe` drives the data while the column strobe is low. For a read, `dram_we_n` is high, `dram_oe_n` is low and `dram_dq_oe` is low.
- R10: `ref_req` closes any open row. `ref_gnt` is asserted only while both strobes are high. `req_ready` stays low while `ref_req` or `ref_gnt` is high. After the grant ends, the row strobe waits the full precharge of R6 before it falls again.
- R11: After reset both strobes, `dram_we_n` and `dram_oe_n` are high, and `dram_dq_oe`, `rsp_valid` and `ref_gnt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh scheduler asks for the bus |
| ref_gnt | output | 1 | Bus released to the refresh scheduler |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Pad driver enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data returned from the memory |

## Verification
The assertions take for granted that the parameters follow the memory's ordering: T_CAS at least 1, T_RCD at least 2 so the row address is held past the row strobe fall, and T_RAS_MAX comfortably above T_RAS_MIN plus T_CAS plus T_RHCP. They also assume `ref_req` stays high until `ref_gnt` is seen. The stimulus keeps within this. It instantiates the block with a short row-low limit (200 cycles) and the 125 MHz rounding of the other limits. It holds each request stable until it is accepted and holds the refresh request until after the grant. A behavioural memory model latches the multiplexed address on the strobe edges, so the row/column split is checked against the memory contents rather than against internal signals.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int ROW_W  = 11;
    localparam int COL_W  = 11;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DQ_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_CAS,
        ST_OPEN,
        ST_REF
    } seq_state_e;

    typedef struct packed {
        logic             we;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
    } acc_req_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_addr_map.sv
module fpm_addr_map
    import fpm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  open_row,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              hit
);
    // Row occupies the upper bits so that sequential words stay in one page.
    assign row = addr[ADDR_W-1:COL_W];
    assign col = addr[COL_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/fpm_timer.sv
module fpm_timer #(
    parameter int CW        = 16,
    parameter int RP_EFF    = 6,
    parameter int T_RAS_MIN = 8,
    parameter int T_RAS_MAX = 12500,
    parameter int T_RHCP    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          pre_clr,
    output logic [CW-1:0] ras_cnt,
    output logic [CW-1:0] cas_hi_cnt,
    output logic [CW-1:0] pre_cnt
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    // Each count is the length an interval will have reached at the next edge.
    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == TOP) ? v : v + ONE;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_cnt    <= ONE;
            cas_hi_cnt <= TOP;
            pre_cnt    <= TOP;
        end else begin
            ras_cnt    <= ras_n ? ONE : sat_inc(ras_cnt);
            cas_hi_cnt <= !cas_n ? ONE : sat_inc(cas_hi_cnt);
            pre_cnt    <= (!ras_n || pre_clr) ? ONE : sat_inc(pre_cnt);
        end
    end

    a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $past(pre_cnt) >= CW'(RP_EFF));

    a_r6_ras_min: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> $past(ras_cnt) >= CW'(T_RAS_MIN));

    a_r7_cas_to_ras_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> $past(cas_hi_cnt) >= CW'(T_RHCP));

    a_r8_ras_max: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> ras_cnt <= CW'(T_RAS_MAX));
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int CW        = 16,
    parameter int T_CAS     = 2,
    parameter int RCD_EFF   = 6,
    parameter int CP_EFF    = 3,
    parameter int RP_EFF    = 6,
    parameter int T_RAS_MIN = 8,
    parameter int T_RHCP    = 5,
    parameter int PAGE_LIM  = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  acc_req_t         req_in,
    input  logic             hit,
    output logic [ROW_W-1:0] open_row,
    input  logic             ref_req,
    output logic             ref_gnt,
    output logic             pre_clr,
    input  logic [CW-1:0]    ras_cnt,
    input  logic [CW-1:0]    cas_hi_cnt,
    input  logic [CW-1:0]    pre_cnt,
    output logic [COL_W-1:0] dram_a,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic             dram_oe_n,
    output logic [DQ_W-1:0]  dram_dq_out,
    output logic             dram_dq_oe,
    input  logic [DQ_W-1:0]  dram_dq_in,
    output logic             rsp_valid,
    output logic [DQ_W-1:0]  rsp_rdata
);
    localparam int KW = $clog2(T_CAS + 1) + 1;

    seq_state_e       state_q;
    acc_req_t         cur_q;
    logic [KW-1:0]    cas_cnt_q;
    logic [ROW_W-1:0] open_row_q;
    logic             ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_q;
    logic [COL_W-1:0] a_q;
    logic [DQ_W-1:0]  dq_q, rdata_q;

    logic pre_ok, page_room, hit_ok, may_close, want_close;

    always_comb begin
        pre_ok     = pre_cnt >= CW'(RP_EFF);
        page_room  = ras_cnt < CW'(PAGE_LIM);
        hit_ok     = hit && page_room && (cas_hi_cnt >= CW'(CP_EFF));
        may_close  = (cas_hi_cnt >= CW'(T_RHCP)) && (ras_cnt >= CW'(T_RAS_MIN));
        want_close = ref_req || (req_valid && !hit) || !page_room;
        req_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = pre_ok && !ref_req;
            ST_OPEN: req_ready = hit_ok && !ref_req;
            default: req_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            cas_cnt_q  <= '0;
            open_row_q <= '0;
            ras_n_q    <= 1'b1;
            cas_n_q    <= 1'b1;
            we_n_q     <= 1'b1;
            oe_n_q     <= 1'b1;
            dq_oe_q    <= 1'b0;
            a_q        <= '0;
            dq_q       <= '0;
            rsp_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            rsp_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_req && pre_ok) begin
                        state_q <= ST_REF;
                    end else if (req_valid && req_ready) begin
                        cur_q      <= req_in;
                        open_row_q <= req_in.row;
                        a_q        <= req_in.row;
                        ras_n_q    <= 1'b0;
                        state_q    <= ST_RCD;
                    end
                end
                ST_RCD: begin
                    if (ras_cnt >= CW'(RCD_EFF)) begin
                        a_q       <= cur_q.col;
                        cas_n_q   <= 1'b0;
                        we_n_q    <= !cur_q.we;
                        oe_n_q    <= cur_q.we;
                        dq_q      <= cur_q.wdata;
                        dq_oe_q   <= cur_q.we;
                        cas_cnt_q <= KW'(1);
                        state_q   <= ST_CAS;
                    end
                end
                ST_CAS: begin
                    if (cas_cnt_q >= KW'(T_CAS)) begin
                        cas_n_q <= 1'b1;
                        we_n_q  <= 1'b1;
                        oe_n_q  <= 1'b1;
                        dq_oe_q <= 1'b0;
                        if (!cur_q.we) begin
                            rsp_q   <= 1'b1;
                            rdata_q <= dram_dq_in;
                        end
                        state_q <= ST_OPEN;
                    end else begin
                        cas_cnt_q <= cas_cnt_q + KW'(1);
                    end
                end
                ST_OPEN: begin
                    if (req_valid && req_ready) begin
                        cur_q     <= req_in;
                        a_q       <= req_in.col;
                        cas_n_q   <= 1'b0;
                        we_n_q    <= !req_in.we;
                        oe_n_q    <= req_in.we;
                        dq_q      <= req_in.wdata;
                        dq_oe_q   <= req_in.we;
                        cas_cnt_q <= KW'(1);
                        state_q   <= ST_CAS;
                    end else if (want_close && may_close) begin
                        ras_n_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_REF: begin
                    if (!ref_req) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign open_row    = open_row_q;
    assign ref_gnt     = (state_q == ST_REF);
    assign pre_clr     = (state_q == ST_REF);
    assign dram_a      = a_q;
    assign dram_ras_n  = ras_n_q;
    assign dram_cas_n  = cas_n_q;
    assign dram_we_n   = we_n_q;
    assign dram_oe_n   = oe_n_q;
    assign dram_dq_out = dq_q;
    assign dram_dq_oe  = dq_oe_q;
    assign rsp_valid   = rsp_q;
    assign rsp_rdata   = rdata_q;

    a_r9_early_write: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n_q) && !we_n_q) |-> (oe_n_q && dq_oe_q));

    a_r9_read_drive: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n_q) && we_n_q) |-> (!oe_n_q && !dq_oe_q));

    a_r3_cas_in_ras: assert property (@(posedge clk) disable iff (rst)
        !cas_n_q |-> !ras_n_q);

    a_r10_gnt_quiet: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (ras_n_q && cas_n_q));

    a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_q |=> !rsp_q);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int T_RP      = 5,
    parameter int T_RC      = 14,
    parameter int T_RCD     = 3,
    parameter int T_RAC     = 8,
    parameter int T_CAS     = 2,
    parameter int T_PC      = 5,
    parameter int T_CP      = 2,
    parameter int T_RHCP    = 5,
    parameter int T_RAS_MIN = 8,
    parameter int T_RAS_MAX = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [DQ_W-1:0]   rsp_rdata,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic [COL_W-1:0]  dram_a,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam int RP_EFF   = max2(T_RP, T_RC - T_RAS_MIN);
    localparam int RCD_EFF  = max2(T_RCD, T_RAC - T_CAS);
    localparam int CP_EFF   = max2(T_CP, T_PC - T_CAS);
    localparam int PAGE_LIM = T_RAS_MAX - (T_CAS + T_RHCP + 2);
    localparam int CW       = $clog2(T_RAS_MAX + 2) + 1;

    logic [ROW_W-1:0] row, open_row;
    logic [COL_W-1:0] col;
    logic             hit, pre_clr;
    logic [CW-1:0]    ras_cnt, cas_hi_cnt, pre_cnt;
    acc_req_t         req_in;

    fpm_addr_map u_map (
        .addr     (req_addr),
        .open_row (open_row),
        .row      (row),
        .col      (col),
        .hit      (hit)
    );

    always_comb begin
        req_in.we    = req_we;
        req_in.row   = row;
        req_in.col   = col;
        req_in.wdata = req_wdata;
    end

    fpm_timer #(
        .CW        (CW),
        .RP_EFF    (RP_EFF),
        .T_RAS_MIN (T_RAS_MIN),
        .T_RAS_MAX (T_RAS_MAX),
        .T_RHCP    (T_RHCP)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .ras_n      (dram_ras_n),
        .cas_n      (dram_cas_n),
        .pre_clr    (pre_clr),
        .ras_cnt    (ras_cnt),
        .cas_hi_cnt (cas_hi_cnt),
        .pre_cnt    (pre_cnt)
    );

    fpm_seq #(
        .CW        (CW),
        .T_CAS     (T_CAS),
        .RCD_EFF   (RCD_EFF),
        .CP_EFF    (CP_EFF),
        .RP_EFF    (RP_EFF),
        .T_RAS_MIN (T_RAS_MIN),
        .T_RHCP    (T_RHCP),
        .PAGE_LIM  (PAGE_LIM)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_in      (req_in),
        .hit         (hit),
        .open_row    (open_row),
        .ref_req     (ref_req),
        .ref_gnt     (ref_gnt),
        .pre_clr     (pre_clr),
        .ras_cnt     (ras_cnt),
        .cas_hi_cnt  (cas_hi_cnt),
        .pre_cnt     (pre_cnt),
        .dram_a      (dram_a),
        .dram_ras_n  (dram_ras_n),
        .dram_cas_n  (dram_cas_n),
        .dram_we_n   (dram_we_n),
        .dram_oe_n   (dram_oe_n),
        .dram_dq_out (dram_dq_out),
        .dram_dq_oe  (dram_dq_oe),
        .dram_dq_in  (dram_dq_in),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );
endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
    localparam int T_RP = 5, T_RC = 14, T_RCD = 3, T_RAC = 8, T_CAS = 2;
    localparam int T_PC = 5, T_CP = 2, T_RHCP = 5, T_RAS_MIN = 8, T_RAS_MAX = 200;
    // Binding counts worked out from the requirements R3, R4, R6.
    localparam int RP_NEED  = (T_RP > T_RC - T_RAS_MIN) ? T_RP : T_RC - T_RAS_MIN;
    localparam int RCD_NEED = (T_RCD > T_RAC - T_CAS) ? T_RCD : T_RAC - T_CAS;
    localparam int CP_NEED  = (T_CP > T_PC - T_CAS) ? T_CP : T_PC - T_CAS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, ref_gnt;
    logic [3:0]  rsp_rdata;
    logic [10:0] dram_a;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_out, dram_dq_in;

    always #4 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RP(T_RP), .T_RC(T_RC), .T_RCD(T_RCD), .T_RAC(T_RAC), .T_CAS(T_CAS),
        .T_PC(T_PC), .T_CP(T_CP), .T_RHCP(T_RHCP), .T_RAS_MIN(T_RAS_MIN),
        .T_RAS_MAX(T_RAS_MAX)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
        .ref_gnt(ref_gnt), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural memory: address halves latched on strobe edges.
    logic [3:0]  mem [logic [21:0]];
    logic [10:0] m_row = '0;
    logic [3:0]  m_rd = '0;
    always @(negedge dram_ras_n) m_row = dram_a;
    always @(negedge dram_cas_n) begin
        if (!dram_we_n) mem[{m_row, dram_a}] = dram_dq_out;
        else m_rd = mem.exists({m_row, dram_a}) ? mem[{m_row, dram_a}] : 4'h0;
    end
    assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? m_rd : 4'h0;

    // Strobe timing monitor, sampled once per cycle at the falling clock edge.
    int ras_falls = 0, mon_events = 0;
    int rl = 0, rh = 1000, chl = 1000, cl = 0;
    bit pr = 1'b1, pc = 1'b1, first_cas = 1'b0, prsp = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pr && !dram_ras_n) begin
                ras_falls++; mon_events++; first_cas = 1'b1;
                if (rh < RP_NEED) check(0, "R6", "precharge cycles", rh, RP_NEED);
            end
            if (!pr && dram_ras_n) begin
                if (rl < T_RAS_MIN) check(0, "R6", "row low cycles", rl, T_RAS_MIN);
                if (rl > T_RAS_MAX) check(0, "R8", "row low cycles", rl, T_RAS_MAX);
                if (chl < T_RHCP) check(0, "R7", "cas high before ras rise", chl, T_RHCP);
            end
            if (pc && !dram_cas_n) begin
                if (dram_ras_n) check(0, "R3", "cas fell with ras high", 1, 0);
                if (first_cas && rl < RCD_NEED) check(0, "R3", "ras to cas", rl, RCD_NEED);
                if (!first_cas && chl < CP_NEED) check(0, "R4", "cas precharge", chl, CP_NEED);
                first_cas = 1'b0;
                if (!dram_we_n && !(dram_oe_n && dram_dq_oe))
                    check(0, "R9", "write oe_n/dq_oe", {dram_oe_n, dram_dq_oe}, 3);
                if (dram_we_n && !(!dram_oe_n && !dram_dq_oe))
                    check(0, "R9", "read oe_n/dq_oe", {dram_oe_n, dram_dq_oe}, 2);
            end
            if (!pc && dram_cas_n && cl != T_CAS) check(0, "R3", "cas low cycles", cl, T_CAS);
            if (prsp && rsp_valid) check(0, "R2", "rsp_valid width", 2, 1);
            if (ref_gnt && !(dram_ras_n && dram_cas_n)) check(0, "R10", "strobes in grant", 0, 1);
            rl  = dram_ras_n ? 0 : rl + 1;
            rh  = dram_ras_n ? rh + 1 : 0;
            chl = dram_cas_n ? chl + 1 : 0;
            cl  = dram_cas_n ? 0 : cl + 1;
            if (ref_gnt) rh = 0;
            pr = dram_ras_n; pc = dram_cas_n; prsp = rsp_valid;
        end
    end

    task automatic do_req(input bit we, input logic [21:0] addr, input logic [3:0] wd,
                          output logic [3:0] rd, output bit got);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        #1;
        guard = 0;
        while (!req_ready && guard < 600) begin
            @(negedge clk); #1; guard++;
        end
        if (guard >= 600) check(0, "R5", "request never accepted", guard, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        got = 1'b0; rd = '0;
        if (!we) begin
            for (int i = 0; i < 40 && !got; i++) begin
                @(negedge clk);
                if (rsp_valid) begin got = 1'b1; rd = rsp_rdata; end
            end
        end else begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (rsp_valid) got = 1'b1;
            end
        end
    endtask

    task automatic write_word(input logic [21:0] addr, input logic [3:0] wd);
        logic [3:0] rd; bit got;
        do_req(1'b1, addr, wd, rd, got);
        check(!got, "R2", "response after write", int'(got), 0);
        check(mem.exists(addr) && mem[addr] == wd, "R1", "memory cell after write",
              mem.exists(addr) ? int'(mem[addr]) : -1, int'(wd));
    endtask

    task automatic read_word(input logic [21:0] addr, input logic [3:0] exp, input string req);
        logic [3:0] rd; bit got;
        do_req(1'b0, addr, 4'h0, rd, got);
        check(got, "R2", "read response present", int'(got), 1);
        check(rd == exp, req, "read data", int'(rd), int'(exp));
    endtask

    task automatic t_reset;
        check(dram_ras_n && dram_cas_n, "R11", "strobes after reset", {dram_ras_n, dram_cas_n}, 3);
        check(dram_we_n && dram_oe_n, "R11", "we_n/oe_n after reset", {dram_we_n, dram_oe_n}, 3);
        check(!dram_dq_oe, "R11", "dq_oe after reset", int'(dram_dq_oe), 0);
        check(!rsp_valid && !ref_gnt, "R11", "rsp/gnt after reset", {rsp_valid, ref_gnt}, 0);
    endtask

    task automatic t_write_read;
        write_word({11'h5A3, 11'h0F1}, 4'h9);
        write_word({11'h5A3, 11'h7FF}, 4'h6);
        read_word({11'h5A3, 11'h0F1}, 4'h9, "R2");
        read_word({11'h5A3, 11'h7FF}, 4'h6, "R1");
    endtask

    task automatic t_page;
        int f0;
        write_word({11'h012, 11'h001}, 4'hC);
        f0 = ras_falls;
        write_word({11'h012, 11'h002}, 4'h3);
        read_word({11'h012, 11'h001}, 4'hC, "R4");
        read_word({11'h012, 11'h002}, 4'h3, "R4");
        check(ras_falls == f0, "R4", "row opens during same-row run", ras_falls - f0, 0);
    endtask

    task automatic t_miss;
        int f0;
        write_word({11'h300, 11'h010}, 4'hA);
        write_word({11'h301, 11'h010}, 4'h5);
        f0 = ras_falls;
        read_word({11'h300, 11'h010}, 4'hA, "R5");
        check(ras_falls == f0 + 1, "R5", "row opens on miss", ras_falls - f0, 1);
        f0 = ras_falls;
        read_word({11'h301, 11'h010}, 4'h5, "R5");
        check(ras_falls == f0 + 1, "R5", "row opens on second miss", ras_falls - f0, 1);
    endtask

    task automatic t_refresh;
        int guard, f0;
        read_word({11'h5A3, 11'h0F1}, 4'h9, "R10");
        @(negedge clk);
        ref_req = 1'b1;
        #1;
        check(!req_ready, "R10", "ready while refresh pending", int'(req_ready), 0);
        guard = 0;
        while (!ref_gnt && guard < 100) begin @(negedge clk); guard++; end
        check(ref_gnt, "R10", "grant reached", int'(ref_gnt), 1);
        check(dram_ras_n && dram_cas_n, "R10", "strobes high in grant", {dram_ras_n, dram_cas_n}, 3);
        repeat (4) @(negedge clk);
        check(ref_gnt && !req_ready, "R10", "grant held, ready low", {ref_gnt, req_ready}, 2);
        ref_req = 1'b0;
        @(negedge clk);
        check(!ref_gnt, "R10", "grant released", int'(ref_gnt), 0);
        f0 = ras_falls;
        read_word({11'h5A3, 11'h0F1}, 4'h9, "R10");
        check(ras_falls == f0 + 1, "R10", "row reopened after refresh", ras_falls - f0, 1);
    endtask

    task automatic t_ras_max;
        int f0;
        write_word({11'h444, 11'h000}, 4'h7);
        f0 = ras_falls;
        for (int i = 0; i < 40; i++) read_word({11'h444, 11'h000}, 4'h7, "R8");
        check(ras_falls > f0, "R8", "forced row close during same-row run", ras_falls - f0, 1);
        f0 = ras_falls;
        repeat (T_RAS_MAX + 20) @(negedge clk);
        check(dram_ras_n, "R8", "idle open row closed", int'(dram_ras_n), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_page();
        t_miss();
        t_refresh();
        t_ras_max();
        repeat (10) @(negedge clk);
        check(mon_events > 0, "R6", "row cycles seen by monitor", mon_events, 1);
        check(mon_events > 0, "R3", "strobe checks performed", mon_events, 1);
        check(mon_events > 0, "R7", "close checks performed", mon_events, 1);
        check(mon_events > 0, "R9", "drive checks performed", mon_events, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R11", "watchdog cycles", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule